// File: doc/BRIEF.md
# Lithium Charge Phase Sequencer with Safety Timer

This controller steps a single lithium cell through a charge cycle: a low-current pre-conditioning phase (trickle), a fast phase covering constant current and constant voltage, and a completed state that waits for the cell to sag before charging again. The analog loops, the current setting and the oscillator are outside the block. It sees only comparator flags, an enable, a timeout-enable and a one-cycle `tick` from the slow oscillator. One saturating tick counter guards both charging phases. Its width `TMR_W` sets the fast-phase limit to 2^TMR_W ticks and the trickle limit to 2^(TMR_W-3) ticks.

A missed deadline latches a fault that stops charging. Over-temperature pauses the cycle, and its recovery restarts the cycle from trickle. With timeout-enable low, the fast phase acts as an open-ended regulator: it keeps charging and only reports end-of-charge on `done`. Every cycle still opens in trickle, and the trickle limit still applies.

Top module: `chg_seq_top`

## Requirements
- R1: While `rst_n` is low, and on leaving reset with `en` low, `phase` is IDLE (0), and `chg_on`, `done` and `fault` are 0. The phase codes are IDLE=0, TRICKLE=1, FAST=2, DONE=3, FAULT=4.
- R2: Each of these events enters TRICKLE with the counter cleared: a rising `en` (including `en` already high at the first edge after reset), a rising `bat_pres`, a falling `ovt`, and `rechg` while in DONE.
- R3: TRICKLE moves to FAST only when `vmin_ok` is high and at least 15 ticks have passed since trickle entry. With `vmin_ok` held high from entry, the move happens on the 16th tick edge. The counter is cleared on entering FAST.
- R4: If TRICKLE sees its 2^(TMR_W-3)-th tick without leaving, the block enters FAULT. This applies whatever the value of `to_en`.
- R5: With `to_en` high, FAST enters FAULT on its 2^TMR_W-th tick if `eoc` is low.
- R6: With `to_en` high, `eoc` in FAST enters DONE: `chg_on`=0 and `done`=1. DONE holds until `rechg` is seen.
- R7: With `to_en` low, FAST never times out. The counter saturates instead of wrapping. `done` follows `eoc` while `chg_on` stays 1.
- R8: FAULT drives `fault`=1 and `chg_on`=0. It holds through `vmin_ok`, `eoc` or battery removal, and only `en` low or reset clears it to IDLE.
- R9: While `ovt` is high (outside FAULT), the phase holds, `chg_on` is 0 and the counter is frozen. When `ovt` falls, the cycle restarts in TRICKLE with the counter cleared.
- R10: When a progression condition (`vmin_ok` after the dwell, or `eoc`) falls in the same cycle as the phase's expiry tick, the progression wins.
- R11: The counter advances only in cycles with `tick` high, so any number of tick-less cycles never causes expiry.
- R12: With `en` high, `bat_pres` low sends any non-fault phase to IDLE, and a rising `en` with no battery stays in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | One-cycle oscillator period pulse |
| en | input | 1 | Charger enable |
| to_en | input | 1 | Fast-phase timeout enable |
| bat_pres | input | 1 | Battery present flag |
| ovt | input | 1 | Over-temperature flag |
| vmin_ok | input | 1 | Battery above pre-conditioning threshold |
| eoc | input | 1 | End-of-charge current reached |
| rechg | input | 1 | Battery below recharge threshold |
| phase | output | 3 | Current phase code |
| chg_on | output | 1 | Charging allowed |
| done | output | 1 | End-of-charge status |
| fault | output | 1 | Latched timeout fault |

## Verification
Two collisions matter: trickle expiry against the arrival of `vmin_ok`, and fast expiry against `eoc`. In each case the bench counts ticks from phase entry up to one tick short of the limit. It then raises the progression flag in exactly the cycle that carries the expiring tick. The result is judged by the next phase: FAST or DONE passes, and FAULT means the expiry was wrongly given priority. A further case checks that an over-temperature pause stops the trickle countdown, so that time spent paused does not count toward the limit.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_TRICKLE = 3'd1,
    PH_FAST    = 3'd2,
    PH_DONE    = 3'd3,
    PH_FAULT   = 3'd4
  } phase_e;

  // last count value before the trickle limit tick: 2^(w-3) - 1
  function automatic int unsigned trk_last(input int unsigned w);
    return (32'd1 << (w - 3)) - 32'd1;
  endfunction

  function automatic logic is_charging(input phase_e p);
    return (p == PH_TRICKLE) || (p == PH_FAST);
  endfunction
endpackage

// File: rtl/chg_evt_detect.sv
module chg_evt_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bat_pres,
  input  logic ovt,
  output logic start_evt
);
  logic en_q, bat_q, ovt_q;
  logic en_rise, bat_rise, ovt_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      bat_q <= 1'b0;
      ovt_q <= 1'b0;
    end else begin
      en_q  <= en;
      bat_q <= bat_pres;
      ovt_q <= ovt;
    end
  end

  assign en_rise   = en && !en_q;
  assign bat_rise  = bat_pres && !bat_q;
  assign ovt_fall  = !ovt && ovt_q;
  assign start_evt = en_rise || bat_rise || ovt_fall;
endmodule

// File: rtl/chg_tick_timer.sv
module chg_tick_timer #(
  parameter int unsigned CNT_W = 22,
  parameter int unsigned DWELL = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             dwell_met,
  output logic             trk_exp,
  output logic             tot_exp
);
  import chg_pkg::*;

  localparam logic [CNT_W-1:0] TRK_LAST  = CNT_W'(trk_last(CNT_W));
  localparam logic [CNT_W-1:0] TOT_LAST  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] DWELL_CNT = CNT_W'(DWELL);

  logic at_top;
  assign at_top = (cnt == TOT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (run && !at_top)  cnt <= cnt + 1'b1;
  end

  assign dwell_met = (cnt >= DWELL_CNT);
  assign trk_exp   = run && (cnt == TRK_LAST);
  assign tot_exp   = run && at_top;

  // R11
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && !clr) |=> (cnt == TOT_LAST));
endmodule

// File: rtl/chg_phase_fsm.sv
module chg_phase_fsm #(
  parameter int unsigned CNT_W = 22,
  parameter int unsigned DWELL = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             to_en,
  input  logic             bat_pres,
  input  logic             ovt,
  input  logic             vmin_ok,
  input  logic             eoc,
  input  logic             rechg,
  input  logic             start_evt,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dwell_met,
  input  logic             trk_exp,
  input  logic             tot_exp,
  output logic             clr,
  output logic             run,
  output logic [2:0]       phase,
  output logic             chg_on,
  output logic             done,
  output logic             fault
);
  import chg_pkg::*;

  phase_e ph_q, nxt;

  always_comb begin
    nxt = ph_q;
    clr = 1'b0;
    if (!en) begin
      nxt = PH_IDLE;
      clr = 1'b1;
    end else if (ph_q == PH_FAULT) begin
      nxt = PH_FAULT;
    end else if (!bat_pres) begin
      nxt = PH_IDLE;
      clr = 1'b1;
    end else if (ovt) begin
      nxt = ph_q;
    end else if (start_evt) begin
      nxt = PH_TRICKLE;
      clr = 1'b1;
    end else begin
      unique case (ph_q)
        PH_TRICKLE: begin
          if (vmin_ok && dwell_met) begin
            nxt = PH_FAST;
            clr = 1'b1;
          end else if (trk_exp) begin
            nxt = PH_FAULT;
          end
        end
        PH_FAST: begin
          if (to_en && eoc) begin
            nxt = PH_DONE;
            clr = 1'b1;
          end else if (to_en && tot_exp) begin
            nxt = PH_FAULT;
          end
        end
        PH_DONE: begin
          if (rechg) begin
            nxt = PH_TRICKLE;
            clr = 1'b1;
          end
        end
        default: nxt = ph_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= nxt;
  end

  assign run    = tick && !ovt && is_charging(ph_q);
  assign phase  = ph_q;
  assign chg_on = is_charging(ph_q) && !ovt;
  assign fault  = (ph_q == PH_FAULT);
  assign done   = (ph_q == PH_DONE) || (ph_q == PH_FAST && !to_en && eoc);

  // R3
  dwell_before_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_TRICKLE && nxt == PH_FAST) |-> (cnt >= CNT_W'(DWELL)));

  // R5
  fast_expiry_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_FAST && en && bat_pres && !ovt && to_en && !eoc && tot_exp)
      |=> (phase == 3'd4));

  // R8
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && en) |=> fault);

  // R9
  ovt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bat_pres && ovt) |=> (phase == $past(phase)));

  // R8
  always_comb begin
    if (rst_n) fault_blocks_charge_chk: assert (!(fault && chg_on));
  end
endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top #(
  parameter int unsigned TMR_W = 22,
  parameter int unsigned DWELL = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       to_en,
  input  logic       bat_pres,
  input  logic       ovt,
  input  logic       vmin_ok,
  input  logic       eoc,
  input  logic       rechg,
  output logic [2:0] phase,
  output logic       chg_on,
  output logic       done,
  output logic       fault
);
  logic             start_evt, clr, run;
  logic             dwell_met, trk_exp, tot_exp;
  logic [TMR_W-1:0] cnt;

  chg_evt_detect u_evt (
    .clk(clk), .rst_n(rst_n), .en(en), .bat_pres(bat_pres), .ovt(ovt),
    .start_evt(start_evt)
  );

  chg_tick_timer #(.CNT_W(TMR_W), .DWELL(DWELL)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .cnt(cnt),
    .dwell_met(dwell_met), .trk_exp(trk_exp), .tot_exp(tot_exp)
  );

  chg_phase_fsm #(.CNT_W(TMR_W), .DWELL(DWELL)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .to_en(to_en),
    .bat_pres(bat_pres), .ovt(ovt), .vmin_ok(vmin_ok), .eoc(eoc),
    .rechg(rechg), .start_evt(start_evt), .cnt(cnt), .dwell_met(dwell_met),
    .trk_exp(trk_exp), .tot_exp(tot_exp), .clr(clr), .run(run),
    .phase(phase), .chg_on(chg_on), .done(done), .fault(fault)
  );
endmodule

// File: tb/tb_chg_seq_top.sv
module tb_chg_seq_top;
  localparam int unsigned W = 8;   // fast limit 256 ticks, trickle limit 32 ticks

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic en = 0, to_en = 0, bat_pres = 0, ovt = 0, vmin_ok = 0, eoc = 0, rechg = 0;
  logic [2:0] phase;
  logic chg_on, done, fault;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  chg_seq_top #(.TMR_W(W), .DWELL(15)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .to_en(to_en),
    .bat_pres(bat_pres), .ovt(ovt), .vmin_ok(vmin_ok), .eoc(eoc),
    .rechg(rechg), .phase(phase), .chg_on(chg_on), .done(done), .fault(fault)
  );

  // stim bits: {en, to_en, bat_pres, ovt, vmin_ok, eoc, rechg}
  typedef struct packed {
    logic [6:0]  stim;
    logic [15:0] cyc;
    logic [2:0]  ph;
    logic        chg, dn, flt;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    '{7'b1110000, 16'd1,   3'd1, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 enable rise
    '{7'b1110100, 16'd15,  3'd1, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 dwell not met
    '{7'b1110100, 16'd1,   3'd2, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 16th tick
    '{7'b1110110, 16'd1,   3'd3, 1'b0, 1'b1, 1'b0, 4'd6},  // R6
    '{7'b1110100, 16'd5,   3'd3, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 hold
    '{7'b1110101, 16'd1,   3'd1, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 recharge
    '{7'b1110000, 16'd31,  3'd1, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
    '{7'b1110000, 16'd1,   3'd4, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 expiry
    '{7'b1110100, 16'd3,   3'd4, 1'b0, 1'b0, 1'b1, 4'd8},  // R8
    '{7'b1100000, 16'd1,   3'd4, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 removal
    '{7'b0110000, 16'd1,   3'd0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 clear
    '{7'b1110000, 16'd1,   3'd1, 1'b1, 1'b0, 1'b0, 4'd2},  // R2
    '{7'b1110100, 16'd16,  3'd2, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
    '{7'b1111100, 16'd10,  3'd2, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 pause
    '{7'b1110000, 16'd1,   3'd1, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 recover
    '{7'b1110100, 16'd16,  3'd2, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
    '{7'b1110100, 16'd255, 3'd2, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
    '{7'b1110100, 16'd1,   3'd4, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 expiry
    '{7'b0110000, 16'd1,   3'd0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{7'b1010000, 16'd1,   3'd1, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 timeout off
    '{7'b1010100, 16'd16,  3'd2, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
    '{7'b1010100, 16'd300, 3'd2, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 no expiry
    '{7'b1010110, 16'd1,   3'd2, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 done shown
    '{7'b1010100, 16'd1,   3'd2, 1'b1, 1'b0, 1'b0, 4'd7},  // R7
    '{7'b0010000, 16'd1,   3'd0, 1'b0, 1'b0, 1'b0, 4'd12}, // R12
    '{7'b1010000, 16'd1,   3'd1, 1'b1, 1'b0, 1'b0, 4'd2},  // R2
    '{7'b1010000, 16'd32,  3'd4, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 with to_en low
    '{7'b0110000, 16'd1,   3'd0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{7'b1100000, 16'd1,   3'd0, 1'b0, 1'b0, 1'b0, 4'd12}, // R12 no battery
    '{7'b1110000, 16'd1,   3'd1, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 battery rise
    '{7'b1110000, 16'd20,  3'd1, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
    '{7'b1111000, 16'd50,  3'd1, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 frozen
    '{7'b1110000, 16'd1,   3'd1, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 restart
    '{7'b1110000, 16'd31,  3'd1, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 cleared
    '{7'b1110000, 16'd1,   3'd4, 1'b0, 1'b0, 1'b1, 4'd9},  // R9
    '{7'b0110000, 16'd1,   3'd0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{7'b1110000, 16'd1,   3'd1, 1'b1, 1'b0, 1'b0, 4'd2},  // R2
    '{7'b1110000, 16'd31,  3'd1, 1'b1, 1'b0, 1'b0, 4'd10}, // R10
    '{7'b1110100, 16'd1,   3'd2, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 vmin wins
    '{7'b1110100, 16'd255, 3'd2, 1'b1, 1'b0, 1'b0, 4'd10}, // R10
    '{7'b1110110, 16'd1,   3'd3, 1'b0, 1'b1, 1'b0, 4'd10}, // R10 eoc wins
    '{7'b1100000, 16'd1,   3'd0, 1'b0, 1'b0, 1'b0, 4'd12}  // R12 removal
  };

  task automatic check(input logic [2:0] eph, input logic echg, input logic edn,
                       input logic eflt, input int req);
    n_chk++;
    if (phase !== eph || chg_on !== echg || done !== edn || fault !== eflt) begin
      n_fail++;
      $display("FAIL R%0d: got ph=%0d chg=%b done=%b flt=%b, exp ph=%0d chg=%b done=%b flt=%b",
               req, phase, chg_on, done, fault, eph, echg, edn, eflt);
    end
  endtask

  task automatic drive(input logic [6:0] s);
    {en, to_en, bat_pres, ovt, vmin_ok, eoc, rechg} = s;
  endtask

  task automatic run_cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got running, exp finished");
    finish_run();
  end

  initial begin
    // R1 reset state
    run_cycles(3);
    check(3'd0, 1'b0, 1'b0, 1'b0, 1);
    rst_n = 1'b1;
    run_cycles(2);
    check(3'd0, 1'b0, 1'b0, 1'b0, 1);

    tick = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].stim);
      run_cycles(int'(VECS[i].cyc));
      check(VECS[i].ph, VECS[i].chg, VECS[i].dn, VECS[i].flt, int'(VECS[i].req));
    end

    // R11: without ticks, trickle never expires
    tick = 1'b0;
    drive(7'b1110000);
    run_cycles(1);
    check(3'd1, 1'b1, 1'b0, 1'b0, 2);
    run_cycles(100);
    check(3'd1, 1'b1, 1'b0, 1'b0, 11);
    tick = 1'b1;
    run_cycles(31);
    check(3'd1, 1'b1, 1'b0, 1'b0, 11);
    run_cycles(1);
    check(3'd4, 1'b0, 1'b0, 1'b1, 11);

    // R1: reset clears a latched fault
    rst_n = 1'b0;
    run_cycles(2);
    check(3'd0, 1'b0, 1'b0, 1'b0, 1);
    // R2: enable already high at the first edge after reset starts a cycle
    rst_n = 1'b1;
    run_cycles(1);
    check(3'd1, 1'b1, 1'b0, 1'b0, 2);

    finish_run();
  end
endmodule